// File: doc/BRIEF.md
# Zero-Operand Stack Execution Core

This block runs a tiny stack-architecture instruction set that has no general-purpose registers. Every instruction arrives on one input channel with a valid/ready handshake. An instruction is a 2-bit opcode, plus a word address that only the memory-moving instructions use. A push copies a word from a small internal data memory onto an 8-entry operand stack. A pop writes the top entry back to memory and removes it. Add and subtract take no operand fields: they consume the two uppermost entries and leave their result in their place.

An expression is evaluated by issuing memory-to-stack moves and operations in postfix order. For example, the sequence push b, push c, add, push d, sub, pop a leaves (b+c)-d in word a.

A separate test port lets the environment load the data memory and read it back combinationally. Two sticky flags report a push that was refused because the stack was full, and an instruction that found too few entries. The stack depth is also brought out as a port.

Top module: `stack_exec_core`

## Requirements
- R1: While rst_n is low, depth reads 0, both flags read 0 and ins_ready reads 0. From the first clock edge after reset is released, ins_ready stays 1.
- R2: Opcode 2'b00 (push) places the data-memory word at ins_addr on top of the stack and raises depth by one. Both are visible after the clock edge that accepts the instruction (ins_valid and ins_ready both high).
- R3: Opcode 2'b01 (pop) writes the top entry to the data-memory word at ins_addr and lowers depth by one. Entries leave in reverse order of arrival.
- R4: Opcode 2'b10 (add) replaces the two uppermost entries with their sum modulo 2^32 and lowers depth by one. No carry is kept.
- R5: Opcode 2'b11 (sub) replaces the two uppermost entries with (entry below the top) minus (top), modulo 2^32, and lowers depth by one.
- R6: The postfix sequence push b, push c, add, push d, sub, pop a stores (b+c)-d at word a.
- R7: A pop with depth 0 sets the underflow flag and changes neither the stack nor the data memory.
- R8: An add or sub with depth below 2 sets the underflow flag and leaves the stack contents and depth unchanged.
- R9: A push with depth equal to the stack capacity (8) sets the overflow flag and is discarded. The stored entries are unchanged.
- R10: Both flags are sticky: once set, they stay at 1 until reset.
- R11: tl_we writes tl_wdata to word tl_addr at the clock edge. tl_rdata shows word tl_addr combinationally. If a pop and a test write target the same word on the same edge, the pop's data is stored.
- R12: A cycle with ins_valid low changes neither depth nor stack contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Instruction present |
| ins_ready | output | 1 | Core accepts an instruction this cycle |
| ins_op | input | 2 | Opcode: 00 push, 01 pop, 10 add, 11 sub |
| ins_addr | input | 4 | Data-memory word address for push and pop |
| tl_we | input | 1 | Test-port write enable |
| tl_addr | input | 4 | Test-port word address |
| tl_wdata | input | 32 | Test-port write data |
| tl_rdata | output | 32 | Test-port read data, combinational |
| depth | output | 4 | Number of valid stack entries |
| ovf_flag | output | 1 | Sticky stack-overflow flag |
| unf_flag | output | 1 | Sticky stack-underflow flag |

## Verification
Every instruction takes effect on the single rising edge that accepts it. Depth, the flags and any memory word written by a pop are therefore due one edge after the handshake. Stack contents become visible through a later pop followed by a combinational test-port read. The bench drives inputs on the falling edge and releases ins_valid on the next falling edge, so exactly one rising edge falls between. It then samples depth, the flags and tl_rdata at that falling edge, half a cycle after the results are due. Arithmetic expectations come from a sweep over pairs of boundary values, with the sum and difference worked out in the bench.

// File: rtl/stk_pkg.sv
package stk_pkg;
   typedef enum logic [1:0] {
      OP_PUSH = 2'b00,
      OP_POP  = 2'b01,
      OP_ADD  = 2'b10,
      OP_SUB  = 2'b11
   } stk_op_e;
endpackage

// File: rtl/stk_dmem.sv
module stk_dmem #(
   parameter int W     = 32,
   parameter int WORDS = 16,
   localparam int AW   = $clog2(WORDS)
) (
   input  logic          clk,
   input  logic          wa_en,
   input  logic [AW-1:0] wa_addr,
   input  logic [W-1:0]  wa_data,
   input  logic          wb_en,
   input  logic [AW-1:0] wb_addr,
   input  logic [W-1:0]  wb_data,
   input  logic [AW-1:0] ra_addr,
   output logic [W-1:0]  ra_data,
   input  logic [AW-1:0] rb_addr,
   output logic [W-1:0]  rb_data
);
   logic [W-1:0] mem [WORDS];

   generate
      if (WORDS < 2) begin : g_bad_words
         $error("stk_dmem: WORDS must be at least 2");
      end
   endgenerate

   // port A (instruction side) wins on an address collision
   always_ff @(posedge clk) begin
      if (wa_en) mem[wa_addr] <= wa_data;
      if (wb_en && !(wa_en && wa_addr == wb_addr)) mem[wb_addr] <= wb_data;
   end

   assign ra_data = mem[ra_addr];
   assign rb_data = mem[rb_addr];
endmodule

// File: rtl/stk_alu.sv
module stk_alu #(
   parameter int W = 32
) (
   input  logic         is_sub,
   input  logic [W-1:0] nos,
   input  logic [W-1:0] tos,
   output logic [W-1:0] res
);
   // second entry is the left operand; results wrap modulo 2^W
   assign res = is_sub ? (nos - tos) : (nos + tos);
endmodule

// File: rtl/stk_file.sv
module stk_file #(
   parameter int W     = 32,
   parameter int DEPTH = 8,
   localparam int CW   = $clog2(DEPTH + 2)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push_en,
   input  logic [W-1:0]  push_data,
   input  logic          pop_en,
   input  logic          arith_en,
   input  logic [W-1:0]  arith_res,
   output logic [W-1:0]  tos,
   output logic [W-1:0]  nos,
   output logic [CW-1:0] count
);
   logic [W-1:0] ent [DEPTH];

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("stk_file: DEPTH must be at least 2");
      end
      for (genvar g = 0; g < DEPTH; g++) begin : g_slot
         logic [W-1:0] q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               q <= '0;
            end else if (push_en && count == CW'(g)) begin
               q <= push_data;
            end else if (arith_en && count == CW'(g + 2)) begin
               q <= arith_res;
            end
         end
         assign ent[g] = q;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
      end else if (push_en) begin
         count <= count + 1'b1;
      end else if (pop_en || arith_en) begin
         count <= count - 1'b1;
      end
   end

   always_comb begin
      tos = '0;
      nos = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (count == CW'(i + 1)) tos = ent[i];
         if (count == CW'(i + 2)) nos = ent[i];
      end
   end

   // R2
   depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));

   // R2
   push_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push_en |=> count == $past(count) + 1'b1);

   // R2
   push_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push_en |=> tos == $past(push_data));
endmodule

// File: rtl/stack_exec_core.sv
module stack_exec_core #(
   parameter int DATA_W      = 32,
   parameter int STACK_DEPTH = 8,
   parameter int MEM_WORDS   = 16,
   localparam int AW         = $clog2(MEM_WORDS),
   localparam int CW         = $clog2(STACK_DEPTH + 2)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ins_valid,
   output logic              ins_ready,
   input  logic [1:0]        ins_op,
   input  logic [AW-1:0]     ins_addr,
   input  logic              tl_we,
   input  logic [AW-1:0]     tl_addr,
   input  logic [DATA_W-1:0] tl_wdata,
   output logic [DATA_W-1:0] tl_rdata,
   output logic [CW-1:0]     depth,
   output logic              ovf_flag,
   output logic              unf_flag
);
   import stk_pkg::*;

   logic              ready_q, ovf_q, unf_q;
   logic              fire, is_push, is_pop, is_arith;
   logic              full, empty, few;
   logic              push_ok, pop_ok, arith_ok;
   logic [DATA_W-1:0] tos, nos, alu_res, mem_word;
   logic [CW-1:0]     count;
   stk_op_e           op;

   assign op       = stk_op_e'(ins_op);
   assign fire     = ins_valid && ready_q;
   assign is_push  = (op == OP_PUSH);
   assign is_pop   = (op == OP_POP);
   assign is_arith = (op == OP_ADD) || (op == OP_SUB);
   assign full     = (count == CW'(STACK_DEPTH));
   assign empty    = (count == '0);
   assign few      = (count < CW'(2));
   assign push_ok  = fire && is_push && !full;
   assign pop_ok   = fire && is_pop && !empty;
   assign arith_ok = fire && is_arith && !few;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ready_q <= 1'b0;
         ovf_q   <= 1'b0;
         unf_q   <= 1'b0;
      end else begin
         ready_q <= 1'b1;
         if (fire && is_push && full) ovf_q <= 1'b1;
         if (fire && ((is_pop && empty) || (is_arith && few))) unf_q <= 1'b1;
      end
   end

   stk_dmem #(.W(DATA_W), .WORDS(MEM_WORDS)) u_mem (
      .clk     (clk),
      .wa_en   (pop_ok),
      .wa_addr (ins_addr),
      .wa_data (tos),
      .wb_en   (tl_we),
      .wb_addr (tl_addr),
      .wb_data (tl_wdata),
      .ra_addr (ins_addr),
      .ra_data (mem_word),
      .rb_addr (tl_addr),
      .rb_data (tl_rdata)
   );

   stk_alu #(.W(DATA_W)) u_alu (
      .is_sub (op == OP_SUB),
      .nos    (nos),
      .tos    (tos),
      .res    (alu_res)
   );

   stk_file #(.W(DATA_W), .DEPTH(STACK_DEPTH)) u_stack (
      .clk       (clk),
      .rst_n     (rst_n),
      .push_en   (push_ok),
      .push_data (mem_word),
      .pop_en    (pop_ok),
      .arith_en  (arith_ok),
      .arith_res (alu_res),
      .tos       (tos),
      .nos       (nos),
      .count     (count)
   );

   assign ins_ready = ready_q;
   assign depth     = count;
   assign ovf_flag  = ovf_q;
   assign unf_flag  = unf_q;

   // R1
   ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ins_ready |=> ins_ready);

   // R10
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_flag |=> ovf_flag);

   // R10
   unf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      unf_flag |=> unf_flag);

   // R9
   full_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && is_push && full) |=> (ovf_flag && $stable(depth) && $stable(tos)));

   // R7
   empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && is_pop && empty) |=> (unf_flag && depth == '0));

   // R8
   short_arith_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && is_arith && few) |=> (unf_flag && $stable(depth) && $stable(tos)));

   // R4
   add_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (arith_ok && op == OP_ADD) |=> tos == $past(nos) + $past(tos));

   // R5
   sub_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (arith_ok && op == OP_SUB) |=> tos == $past(nos) - $past(tos));

   // R12
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ins_valid |=> $stable(depth));
endmodule

// File: tb/tb_stack_exec_core.sv
`timescale 1ns/1ps
module tb_stack_exec_core;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        ins_valid;
   logic        ins_ready;
   logic [1:0]  ins_op;
   logic [3:0]  ins_addr;
   logic        tl_we;
   logic [3:0]  tl_addr;
   logic [31:0] tl_wdata;
   logic [31:0] tl_rdata;
   logic [3:0]  depth;
   logic        ovf_flag, unf_flag;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #2.5 clk = ~clk;

   stack_exec_core dut (
      .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
      .ins_op(ins_op), .ins_addr(ins_addr), .tl_we(tl_we), .tl_addr(tl_addr),
      .tl_wdata(tl_wdata), .tl_rdata(tl_rdata), .depth(depth),
      .ovf_flag(ovf_flag), .unf_flag(unf_flag)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; ins_valid = 1'b0; tl_we = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic issue(logic [1:0] op, logic [3:0] addr);
      @(negedge clk);
      ins_valid = 1'b1; ins_op = op; ins_addr = addr;
      @(negedge clk);
      ins_valid = 1'b0;
   endtask

   task automatic twrite(logic [3:0] addr, logic [31:0] data);
      @(negedge clk);
      tl_we = 1'b1; tl_addr = addr; tl_wdata = data;
      @(negedge clk);
      tl_we = 1'b0;
   endtask

   task automatic tread(logic [3:0] addr, output logic [31:0] data);
      tl_addr = addr;
      #0.5;
      data = tl_rdata;
   endtask

   function automatic logic [31:0] pat(int i);
      return 32'h0101_0101 * i + 32'hA5;
   endfunction

   initial begin
      #400000;
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] rd;
      logic [31:0] vals [6];
      vals[0] = 32'h0; vals[1] = 32'h1; vals[2] = 32'h7FFF_FFFF;
      vals[3] = 32'h8000_0000; vals[4] = 32'hFFFF_FFFF; vals[5] = 32'h1234_5678;
      rst_n = 1'b0; ins_valid = 1'b0; ins_op = 2'b00; ins_addr = '0;
      tl_we = 1'b0; tl_addr = '0; tl_wdata = '0;
      @(negedge clk); @(negedge clk);
      // R1 values during reset
      check("R1 depth in reset", 32'(depth), 0);
      check("R1 ovf in reset", 32'(ovf_flag), 0);
      check("R1 unf in reset", 32'(unf_flag), 0);
      check("R1 ready in reset", 32'(ins_ready), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 ready after reset", 32'(ins_ready), 1);

      // R11 load and read back every word
      for (int i = 0; i < 16; i++) twrite(4'(i), pat(i));
      for (int i = 0; i < 16; i++) begin
         tread(4'(i), rd);
         check("R11 test port readback", rd, pat(i));
      end

      // R2 fill the stack
      for (int i = 0; i < 8; i++) begin
         issue(2'b00, 4'(i));
         check("R2 depth after push", 32'(depth), 32'(i + 1));
      end
      // R9 push onto full stack
      issue(2'b00, 4'd9);
      check("R9 overflow flag", 32'(ovf_flag), 1);
      check("R9 depth held when full", 32'(depth), 8);
      // R12 idle cycles
      ins_op = 2'b01;
      repeat (3) @(negedge clk);
      check("R12 depth with valid low", 32'(depth), 8);
      // R3 drain in reverse order; R9 stored entries unchanged
      for (int i = 7; i >= 0; i--) begin
         issue(2'b01, 4'd12);
         tread(4'd12, rd);
         check("R3 R9 popped word", rd, pat(i));
         check("R3 depth after pop", 32'(depth), 32'(i));
      end
      check("R10 overflow stays set", 32'(ovf_flag), 1);
      // R7 pop on empty
      twrite(4'd13, 32'hDEAD_0013);
      issue(2'b01, 4'd13);
      check("R7 underflow flag", 32'(unf_flag), 1);
      check("R7 depth stays 0", 32'(depth), 0);
      tread(4'd13, rd);
      check("R7 memory untouched", rd, 32'hDEAD_0013);

      // R8 short arithmetic
      do_reset();
      check("R1 flags cleared by reset", 32'({ovf_flag, unf_flag}), 0);
      issue(2'b10, 4'd0);
      check("R8 add on empty flag", 32'(unf_flag), 1);
      check("R8 add on empty depth", 32'(depth), 0);
      twrite(4'd0, 32'h0000_0055);
      issue(2'b00, 4'd0);
      issue(2'b11, 4'd0);
      check("R8 sub with one entry depth", 32'(depth), 1);
      check("R10 underflow stays set", 32'(unf_flag), 1);
      issue(2'b01, 4'd3);
      tread(4'd3, rd);
      check("R8 entry unchanged", rd, 32'h0000_0055);

      // R4 R5 sweep over boundary pairs
      do_reset();
      for (int a = 0; a < 6; a++) begin
         for (int b = 0; b < 6; b++) begin
            for (int s = 0; s < 2; s++) begin
               twrite(4'd0, vals[a]);
               twrite(4'd1, vals[b]);
               issue(2'b00, 4'd0);
               issue(2'b00, 4'd1);
               issue(s ? 2'b11 : 2'b10, 4'd0);
               check(s ? "R5 depth after sub" : "R4 depth after add", 32'(depth), 1);
               issue(2'b01, 4'd2);
               tread(4'd2, rd);
               if (s) check("R5 second minus top", rd, vals[a] - vals[b]);
               else   check("R4 wrapped sum", rd, vals[a] + vals[b]);
            end
         end
      end
      check("R4 R5 no flags", 32'({ovf_flag, unf_flag}), 0);

      // R6 postfix expression
      twrite(4'd4, 32'd1000);
      twrite(4'd5, 32'd234);
      twrite(4'd6, 32'd2000);
      issue(2'b00, 4'd4);
      issue(2'b00, 4'd5);
      issue(2'b10, 4'd0);
      issue(2'b00, 4'd6);
      issue(2'b11, 4'd0);
      issue(2'b01, 4'd7);
      tread(4'd7, rd);
      check("R6 postfix result", rd, 32'd1234 - 32'd2000);
      check("R6 depth after expression", 32'(depth), 0);

      // R11 pop and test write collide
      twrite(4'd8, 32'h0BAD_CAFE);
      issue(2'b00, 4'd8);
      @(negedge clk);
      ins_valid = 1'b1; ins_op = 2'b01; ins_addr = 4'd9;
      tl_we = 1'b1; tl_addr = 4'd9; tl_wdata = 32'h1111_2222;
      @(negedge clk);
      ins_valid = 1'b0; tl_we = 1'b0;
      tread(4'd9, rd);
      check("R11 pop wins collision", rd, 32'h0BAD_CAFE);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule